// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Unit

This unit builds a 512-bit vector destination from sixteen 32-bit lane results. On each accepted request it picks an operand for every lane, passes it through a small per-lane function, and then chooses what each lane of the destination receives. A lane can take its computed result, keep the value it held before, or be cleared. The chosen value depends on the lane's write-mask bit, the masking style, whether the mask is in use at all, and whether the lane lies inside the selected vector length. The per-lane function here is a sign flip, which stands in for the real arithmetic. A parameter can change it to a plain pass-through.

The previous destination contents arrive on an input port, so merge masking needs no register-file read inside the block. The assembled destination is registered. It is presented, together with a one-cycle valid pulse, on the cycle after the request strobe, and it holds steady until the next request.

Control is a two-state machine. ST_IDLE means no fresh result is presented. ST_DONE means the registered destination was written on the last edge. The transitions are IDLE_TO_DONE and DONE_TO_DONE on a request, DONE_TO_IDLE when no request arrives, and IDLE_STAY otherwise.

Top module: `lane_wb_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dest_out` is all zeros and `out_valid` is 0.
- R2: When `in_valid` is 1 at a rising edge, `out_valid` is 1 and `dest_out` carries the new destination after that edge. When `in_valid` is 0 at an edge, `out_valid` is 0 and `dest_out` keeps its value.
- R3: Lane j occupies bits 32j+31:32j. An active lane whose mask bit is 1 receives its operand with bit 31 inverted (the sign-flip lane function).
- R4: When `use_mask` is 0, every active lane receives its computed result whatever the mask bits are.
- R5: When both `bcast` and `src_is_mem` are 1, every lane uses source bits 31:0 as its operand. When either of them is 0, each lane uses its own source element.
- R6: With masking in use and `zero_mode` 0, an active lane whose mask bit is 0 receives the same lane of `dest_old`.
- R7: With masking in use and `zero_mode` 1, an active lane whose mask bit is 0 receives zero.
- R8: `vlen_sel` encodes 0 = 128 bits (4 lanes), 1 = 256 bits (8 lanes), 2 = 512 bits (16 lanes), and 3 also selects 16 lanes. All destination bits above the active length are zero.
- R9: Mask bits at or above the active lane count have no effect on `dest_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is 1 |
| vlen_sel | input | 2 | Vector length select (see R8) |
| use_mask | input | 1 | 1 = apply the write mask, 0 = write every active lane |
| zero_mode | input | 1 | 1 = masked-off lanes are zeroed, 0 = they are merged |
| bcast | input | 1 | Broadcast request |
| src_is_mem | input | 1 | Source is a memory operand (broadcast is valid only then) |
| mask | input | 16 | Per-lane write mask, bit j for lane j |
| src | input | 512 | Packed source lanes |
| dest_old | input | 512 | Previous destination value used for merging |
| dest_out | output | 512 | Registered assembled destination |
| out_valid | output | 1 | Pulses 1 on the cycle after an accepted request |

## Verification
Every result of this block is due exactly one rising edge after the request strobe: the destination register and the valid pulse both load on that edge. On the following cycle the valid pulse must drop and the destination must hold. The bench drives each request on a falling edge and holds the strobe for one clock. It checks `dest_out` and `out_valid` on the next falling edge, then checks on one more falling edge that the pulse has dropped and the value has held. Because every sample is taken half a cycle away from the rising edge, no check depends on the order of events at the edge.

// File: rtl/lane_wb_pkg.sv
package lane_wb_pkg;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } wb_state_e;

endpackage

// File: rtl/lane_func.sv
module lane_func #(
    parameter int W    = 32,
    parameter int KIND = 0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    generate
        if (KIND == 0) begin : g_signflip
            assign y = {~a[W-1], a[W-2:0]};
        end else begin : g_pass
            assign y = a;
        end
    endgenerate
endmodule

// File: rtl/lane_operand_mux.sv
module lane_operand_mux #(
    parameter int W = 32,
    parameter int N = 16
) (
    input  logic [N*W-1:0] src,
    input  logic           use_elem0,
    output logic [N*W-1:0] opnd
);
    generate
        for (genvar j = 0; j < N; j++) begin : g_lane
            assign opnd[j*W +: W] = use_elem0 ? src[W-1:0] : src[j*W +: W];
        end
    endgenerate
endmodule

// File: rtl/lane_writeback.sv
module lane_writeback #(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic [W-1:0] old,
    input  logic         active,
    input  logic         enable,
    input  logic         zero_mode,
    output logic [W-1:0] y
);
    always_comb begin
        if (!active) begin
            y = '0;
        end else if (enable) begin
            y = result;
        end else if (zero_mode) begin
            y = '0;
        end else begin
            y = old;
        end
    end
endmodule

// File: rtl/lane_wb_unit.sv
module lane_wb_unit
    import lane_wb_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int MAX_LANES = 16,
    parameter int FUNC_KIND = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    vlen_sel,
    input  logic                          use_mask,
    input  logic                          zero_mode,
    input  logic                          bcast,
    input  logic                          src_is_mem,
    input  logic [MAX_LANES-1:0]          mask,
    input  logic [LANE_W*MAX_LANES-1:0]   src,
    input  logic [LANE_W*MAX_LANES-1:0]   dest_old,
    output logic [LANE_W*MAX_LANES-1:0]   dest_out,
    output logic                          out_valid
);
    localparam int VEC_W = LANE_W * MAX_LANES;
    localparam int CNT_W = $clog2(MAX_LANES) + 1;

    wb_state_e state_q, state_d;
    logic [VEC_W-1:0]     operands;
    logic [VEC_W-1:0]     results;
    logic [VEC_W-1:0]     dest_d;
    logic [CNT_W-1:0]     active_cnt;
    logic [MAX_LANES-1:0] lane_active;
    logic                 take_elem0;

    assign take_elem0 = bcast & src_is_mem;

    always_comb begin
        unique case (vlen_e'(vlen_sel))
            VL_128:  active_cnt = CNT_W'(MAX_LANES / 4);
            VL_256:  active_cnt = CNT_W'(MAX_LANES / 2);
            VL_512:  active_cnt = CNT_W'(MAX_LANES);
            VL_RSVD: active_cnt = CNT_W'(MAX_LANES);
        endcase
    end

    lane_operand_mux #(.W(LANE_W), .N(MAX_LANES)) u_opmux (
        .src       (src),
        .use_elem0 (take_elem0),
        .opnd      (operands)
    );

    generate
        for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
            assign lane_active[j] = (CNT_W'(j) < active_cnt);

            lane_func #(.W(LANE_W), .KIND(FUNC_KIND)) u_func (
                .a (operands[j*LANE_W +: LANE_W]),
                .y (results[j*LANE_W +: LANE_W])
            );

            lane_writeback #(.W(LANE_W)) u_wb (
                .result    (results[j*LANE_W +: LANE_W]),
                .old       (dest_old[j*LANE_W +: LANE_W]),
                .active    (lane_active[j]),
                .enable    (mask[j] | ~use_mask),
                .zero_mode (zero_mode),
                .y         (dest_d[j*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_out <= '0;
        end else if (in_valid) begin
            dest_out <= dest_d;
        end
    end

    assign out_valid = (state_q == ST_DONE);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dest_out)));

    // R8
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd0) |=> (dest_out[VEC_W-1:VEC_W/4] == '0));

    // R7
    zero_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_mask && zero_mode && !mask[0]) |=> (dest_out[LANE_W-1:0] == '0));

    // R6
    merge_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_mask && !zero_mode && !mask[0])
        |=> (dest_out[LANE_W-1:0] == $past(dest_old[LANE_W-1:0])));
endmodule

// File: tb/lane_wb_unit_test.sv
module lane_wb_unit_test;
    localparam int W  = 32;
    localparam int N  = 16;
    localparam int VW = W * N;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    vlen_sel;
    logic          use_mask, zero_mode, bcast, src_is_mem;
    logic [N-1:0]  mask;
    logic [VW-1:0] src, dest_old;
    logic [VW-1:0] dest_out;
    logic          out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lane_wb_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .use_mask(use_mask), .zero_mode(zero_mode), .bcast(bcast),
        .src_is_mem(src_is_mem), .mask(mask), .src(src), .dest_old(dest_old),
        .dest_out(dest_out), .out_valid(out_valid)
    );

    function automatic logic [VW-1:0] model(
        input logic [1:0] vs, input logic um, input logic zm, input logic bc,
        input logic mem, input logic [N-1:0] mk, input logic [VW-1:0] s,
        input logic [VW-1:0] old);
        logic [VW-1:0] r;
        int cnt;
        cnt = (vs == 2'd0) ? 4 : (vs == 2'd1) ? 8 : 16;
        r = '0;
        for (int j = 0; j < N; j++) begin
            logic [W-1:0] op;
            op = (bc && mem) ? s[W-1:0] : s[j*W +: W];
            if (j < cnt) begin
                if (mk[j] || !um)  r[j*W +: W] = op ^ 32'h8000_0000;
                else if (zm)       r[j*W +: W] = '0;
                else               r[j*W +: W] = old[j*W +: W];
            end
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] act,
                             input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = $urandom;
        return v;
    endfunction

    task automatic run_req(input string tag, input logic [1:0] vs, input logic um,
                           input logic zm, input logic bc, input logic mem,
                           input logic [N-1:0] mk, input logic [VW-1:0] s,
                           input logic [VW-1:0] old);
        logic [VW-1:0] exp;
        @(negedge clk);
        vlen_sel = vs; use_mask = um; zero_mode = zm; bcast = bc;
        src_is_mem = mem; mask = mk; src = s; dest_old = old; in_valid = 1'b1;
        exp = model(vs, um, zm, bc, mem, mk, s, old);
        @(negedge clk);
        in_valid = 1'b0;
        src = rand_vec(); dest_old = rand_vec(); mask = 16'($urandom);
        check_bit({tag, " R2 valid"}, out_valid, 1'b1);
        check_vec(tag, dest_out, exp);
        @(negedge clk);
        check_bit("R2 valid drop", out_valid, 1'b0);
        check_vec("R2 hold", dest_out, exp);
    endtask

    initial begin
        logic [VW-1:0] s, o;
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0; in_valid = 1'b0; vlen_sel = '0; use_mask = 1'b0;
        zero_mode = 1'b0; bcast = 1'b0; src_is_mem = 1'b0; mask = '0;
        src = '0; dest_old = '0;
        repeat (3) @(negedge clk);
        check_vec("R1 reset dest", dest_out, '0);
        check_bit("R1 reset valid", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 after reset dest", dest_out, '0);
        check_bit("R1 after reset valid", out_valid, 1'b0);

        s = rand_vec(); o = rand_vec();
        run_req("R3 all mask set 512", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, s, o);
        run_req("R4 no mask 256", 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, s, o);
        run_req("R5 broadcast mem", 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 16'hA5C3, s, o);
        run_req("R5 broadcast reg ignored", 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, s, o);
        run_req("R6 merge", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0F0F, s, o);
        run_req("R7 zeroing", 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h3C3C, s, o);
        run_req("R8 len 128", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, s, o);
        run_req("R8 code 3", 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8001, s, o);
        run_req("R9 high mask bits 128", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFF0, s, o);
        run_req("R9 high mask bits 256", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFF05, s, o);

        for (int t = 0; t < 300; t++) begin
            run_req("R3 R6 R7 R8 random", 2'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 16'($urandom), rand_vec(), rand_vec());
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule